// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

A single-port synchronous SRAM with registered inputs, a registered read path and a two-bit internal burst counter. Every control is sampled on the rising clock edge. A new access opens when one of two address strobes is low. A processor-side strobe always reads. A controller-side strobe reads or writes, according to the write controls. Cycles without a strobe continue the open burst. The burst address either steps or stays put, depending on the advance input.

The word is split into byte lanes. A write can change any subset of the lanes, or all of them when global write is low. Read data goes through an output register. The output drivers stay on for one extra cycle after a deselect, so that banks sharing a bus can hand it over without a dead cycle. The output enable gates the drivers without passing through any register. The burst order is fixed when the block is built: either a linear wrap within four words or an interleaved (XOR) order.

Top module: `sram_pipe_burst`

## Requirements
- R1: During and after reset, `data_valid_o` and `data_oe_o` are low until a read has passed through the pipeline.
- R2: A low `adsp_ni` with `ce1_ni` low, `ce2_i` high and `ce3_ni` low starts a read at `addr_i`. The word shows on `data_o`, with `data_valid_o` high, after the second rising edge counted from the capturing edge.
- R3: A low `adsc_ni` (with `adsp_ni` not taken) on a selected chip starts an access at `addr_i`. It is a write when any lane write is requested, and a read otherwise. Write data is taken on the same edge as the address.
- R4: With `gw_ni` high and `bw_en_ni` low, lane i (data bits 9i+8 down to 9i) is written only when `bwe_ni[i]` is low. All other lanes keep their value.
- R5: With `gw_ni` low, all four lanes are written, whatever `bw_en_ni` and `bwe_ni` hold.
- R6: In a cycle with no strobe taken and `adv_ni` low, an open burst steps its two low address bits. With INTERLEAVED=0 the order is (start+n) mod 4. With INTERLEAVED=1 it is start XOR n. The upper address bits stay fixed.
- R7: In a cycle with no strobe taken and `adv_ni` high, the open burst reads or writes the same address again.
- R8: In a cycle with no strobe taken, an open burst with write controls asserted writes at the current burst address.
- R9: `adsp_ni` is ignored while `ce1_ni` is high. That cycle is then handled as a controller-strobe cycle or a continuation.
- R10: A strobe cycle on an unselected chip (`ce1_ni` high, `ce2_i` low or `ce3_ni` high) closes the burst. It writes nothing and yields no read data.
- R11: After a deselect that follows a read, `data_oe_o` stays high for exactly one more cycle. During that cycle `data_valid_o` is low and `data_o` holds the last word. Then `data_oe_o` drops.
- R12: `oe_ni` high forces `data_oe_o` low and `data_o` to zero at once, without a clock edge. The pipeline is not disturbed.
- R13: A read of an address written in the cycle just before returns the new data.
- R14: An access started by `adsp_ni` is a read even when write controls are asserted. Memory is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Word address |
| data_i | input | 36 | Write data, four 9-bit lanes |
| ce1_ni | input | 1 | Primary chip enable, active low |
| ce2_i | input | 1 | Chip enable, active high |
| ce3_ni | input | 1 | Chip enable, active low |
| adsp_ni | input | 1 | Processor address strobe, active low |
| adsc_ni | input | 1 | Controller address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| bwe_ni | input | 4 | Per-lane write enables, active low |
| bw_en_ni | input | 1 | Lane write enable gate, active low |
| gw_ni | input | 1 | Global write, active low |
| oe_ni | input | 1 | Output enable, asynchronous, active low |
| data_o | output | 36 | Read data, zero when not driven |
| data_oe_o | output | 1 | Output driver enable |
| data_valid_o | output | 1 | Fresh read data on data_o |

## Verification
Reads are tried from both strobes. A processor-strobe read that carries write controls tells apart strobe priority from write decoding. A controller-strobe read with lane enables set but the lane gate high tells apart the lane gate from the lane bits. Bursts start at an odd offset, where linear and interleaved orders differ, and run until a deselect, so the last beat also exposes the extra driven cycle. Hold, continuation writes, partial-lane writes over a known word, and strobes on an unselected chip each show up by reading back the exact words later.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_kind_e;
endpackage

// File: rtl/sram_burst_ctr.sv
module sram_burst_ctr #(
  parameter int ADDR_W      = 8,
  parameter int BURST_W     = 2,
  parameter bit INTERLEAVED = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0]  base_q, start;
  logic [BURST_W-1:0] cnt_q, cnt_d, lo;

  always_comb begin
    start = load_i ? addr_i : base_q;
    if (load_i)     cnt_d = '0;
    else if (adv_i) cnt_d = cnt_q + 1'b1;
    else            cnt_d = cnt_q;
  end

  generate
    if (INTERLEAVED) begin : g_ilv
      assign lo = start[BURST_W-1:0] ^ cnt_d;
    end else begin : g_lin
      assign lo = start[BURST_W-1:0] + cnt_d;
    end
  endgenerate

  assign addr_o = {start[ADDR_W-1:BURST_W], lo};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      base_q <= start;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic                    rd_en_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES-1:0]        wr_mask_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] mem_q [DEPTH];
      logic [LANE_W-1:0] rd_q;

      always_ff @(posedge clk_i) begin
        if (wr_en_i && wr_mask_i[l]) mem_q[addr_i] <= wdata_i[l*LANE_W +: LANE_W];
      end

      // output register only moves on a read, so it holds through the extra drive cycle
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      rd_q <= '0;
        else if (rd_en_i) rd_q <= mem_q[addr_i];
      end

      assign rdata_o[l*LANE_W +: LANE_W] = rd_q;
    end
  endgenerate
endmodule

// File: rtl/sram_dcd_out.sv
module sram_dcd_out #(
  parameter int DATA_W = 36
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_fire_i,
  input  logic              idle_i,
  input  logic              oe_ni,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              data_valid_o
);
  logic valid_q, ext_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      ext_q   <= 1'b0;
    end else begin
      valid_q <= rd_fire_i;
      ext_q   <= idle_i & valid_q;
    end
  end

  assign data_oe_o    = !oe_ni && (valid_q || ext_q);
  assign data_o       = data_oe_o ? rdata_i : '0;
  assign data_valid_o = valid_q;

  // R2
  rd_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_fire_i |=> data_valid_o);

  // R11
  dcd_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (data_valid_o || $past(data_valid_o)));

  // R12
  oe_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> (!data_oe_o && data_o == '0));
endmodule

// File: rtl/sram_pipe_burst.sv
module sram_pipe_burst
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int LANES       = 4,
  parameter int LANE_W      = 9,
  parameter int BURST_W     = 2,
  parameter bit INTERLEAVED = 1'b0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] data_i,
  input  logic                    ce1_ni,
  input  logic                    ce2_i,
  input  logic                    ce3_ni,
  input  logic                    adsp_ni,
  input  logic                    adsc_ni,
  input  logic                    adv_ni,
  input  logic [LANES-1:0]        bwe_ni,
  input  logic                    bw_en_ni,
  input  logic                    gw_ni,
  input  logic                    oe_ni,
  output logic [LANES*LANE_W-1:0] data_o,
  output logic                    data_oe_o,
  output logic                    data_valid_o
);
  localparam int DATA_W = LANES * LANE_W;

  logic              chip_sel, p_take, c_take, strobe, load, desel, cont, wr_req;
  logic [LANES-1:0]  lane_we;
  logic [ADDR_W-1:0] cur_addr;
  logic              act_q;
  op_kind_e          kind_d, s1_kind_q;
  logic [ADDR_W-1:0] s1_addr_q;
  logic [DATA_W-1:0] s1_data_q, rdata;
  logic [LANES-1:0]  s1_mask_q;

  always_comb begin
    chip_sel = !ce1_ni && ce2_i && !ce3_ni;
    p_take   = !adsp_ni && !ce1_ni;        // processor strobe gated by primary enable
    c_take   = !adsc_ni && !p_take;
    strobe   = p_take || c_take;
    load     = strobe && chip_sel;
    desel    = strobe && !chip_sel;
    cont     = !strobe && act_q;
    if (!gw_ni)         lane_we = '1;
    else if (!bw_en_ni) lane_we = ~bwe_ni;
    else                lane_we = '0;
    wr_req = |lane_we;
    if (load && p_take)       kind_d = OP_READ;
    else if (load || cont)    kind_d = wr_req ? OP_WRITE : OP_READ;
    else                      kind_d = OP_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    act_q <= 1'b0;
    else if (load)  act_q <= 1'b1;
    else if (desel) act_q <= 1'b0;
  end

  sram_burst_ctr #(
    .ADDR_W(ADDR_W), .BURST_W(BURST_W), .INTERLEAVED(INTERLEAVED)
  ) u_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .adv_i (cont && !adv_ni),
    .addr_i(addr_i),
    .addr_o(cur_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_kind_q <= OP_IDLE;
      s1_addr_q <= '0;
      s1_data_q <= '0;
      s1_mask_q <= '0;
    end else begin
      s1_kind_q <= kind_d;
      s1_addr_q <= cur_addr;
      s1_data_q <= data_i;
      s1_mask_q <= lane_we;
    end
  end

  sram_lane_array #(
    .ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)
  ) u_array (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (s1_kind_q == OP_WRITE),
    .rd_en_i  (s1_kind_q == OP_READ),
    .addr_i   (s1_addr_q),
    .wr_mask_i(s1_mask_q),
    .wdata_i  (s1_data_q),
    .rdata_o  (rdata)
  );

  sram_dcd_out #(.DATA_W(DATA_W)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_fire_i   (s1_kind_q == OP_READ),
    .idle_i      (s1_kind_q == OP_IDLE),
    .oe_ni       (oe_ni),
    .rdata_i     (rdata),
    .data_o      (data_o),
    .data_oe_o   (data_oe_o),
    .data_valid_o(data_valid_o)
  );

  // R14
  adsp_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adsp_ni && !ce1_ni && ce2_i && !ce3_ni) |=> (s1_kind_q == OP_READ));

  // R5
  global_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adsc_ni && adsp_ni && !ce1_ni && ce2_i && !ce3_ni && !gw_ni)
      |=> (s1_kind_q == OP_WRITE && s1_mask_q == '1));

  // R10
  desel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adsc_ni && adsp_ni && ce1_ni) |=> (s1_kind_q == OP_IDLE));

  // R7
  hold_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adsc_ni && (adsp_ni || ce1_ni) && act_q && adv_ni)
      |=> (s1_addr_q == $past(s1_addr_q)));

  // R6
  burst_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adsc_ni && (adsp_ni || ce1_ni) && act_q)
      |=> (s1_addr_q[ADDR_W-1:BURST_W] == $past(s1_addr_q[ADDR_W-1:BURST_W])));
endmodule

// File: tb/sram_pipe_burst_bench.sv
module sram_pipe_burst_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [35:0] din = '0;
  logic        ce1_n, ce2, ce3_n, adsp_n, adsc_n, adv_n, bw_en_n, gw_n, oe_n;
  logic [3:0]  bwe_n;
  logic [35:0] dout, dout_il;
  logic        doe, doe_il, dvalid, dvalid_il;
  logic [35:0] mdl [256];
  int          checks = 0;
  int          errors = 0;

  always #10 clk = ~clk;

  sram_pipe_burst u_sram_pipe_burst (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_i(din),
    .ce1_ni(ce1_n), .ce2_i(ce2), .ce3_ni(ce3_n), .adsp_ni(adsp_n),
    .adsc_ni(adsc_n), .adv_ni(adv_n), .bwe_ni(bwe_n), .bw_en_ni(bw_en_n),
    .gw_ni(gw_n), .oe_ni(oe_n), .data_o(dout), .data_oe_o(doe),
    .data_valid_o(dvalid)
  );

  sram_pipe_burst #(.INTERLEAVED(1'b1)) u_sram_pipe_burst_il (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_i(din),
    .ce1_ni(ce1_n), .ce2_i(ce2), .ce3_ni(ce3_n), .adsp_ni(adsp_n),
    .adsc_ni(adsc_n), .adv_ni(adv_n), .bwe_ni(bwe_n), .bw_en_ni(bw_en_n),
    .gw_ni(gw_n), .oe_ni(oe_n), .data_o(dout_il), .data_oe_o(doe_il),
    .data_valid_o(dvalid_il)
  );

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic check(string req, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    adsp_n = 1; adsc_n = 0; ce1_n = 1; ce2 = 1; ce3_n = 0; adv_n = 1;
    gw_n = 1; bw_en_n = 1; bwe_n = '1; oe_n = 0;
  endtask

  task automatic wr_word(logic [7:0] a, logic [35:0] d);
    adsp_n = 1; adsc_n = 0; ce1_n = 0; addr = a; din = d; gw_n = 0;
    step();
    mdl[a] = d;
    idle();
  endtask

  task automatic rd_check(string req, logic [7:0] a);
    adsp_n = 0; ce1_n = 0; adsc_n = 1; addr = a;
    step();
    idle();
    step();
    check(req, {35'd0, dvalid}, 36'd1);
    check(req, dout, mdl[a]);
    step();
  endtask

  task automatic t_reset();
    idle();
    repeat (3) step();
    check("R1 reset oe", {35'd0, doe}, 36'd0);
    check("R1 reset valid", {35'd0, dvalid}, 36'd0);
    rst_n = 1;
    step(); step();
    check("R1 after reset oe", {35'd0, doe}, 36'd0);
    check("R1 after reset valid", {35'd0, dvalid}, 36'd0);
  endtask

  task automatic t_read_after_write();
    wr_word(8'h10, 36'h1_2345_6789);
    // R13 read issued on the very next edge
    adsp_n = 0; ce1_n = 0; adsc_n = 1; addr = 8'h10;
    step();
    idle();
    step();
    check("R13 valid", {35'd0, dvalid}, 36'd1);
    check("R13 new data", dout, 36'h1_2345_6789);
    step();
    rd_check("R2 plain read", 8'h10);
  endtask

  task automatic t_bytes();
    logic [35:0] exp;
    wr_word(8'h20, 36'hA_AAAA_AAAA);
    adsp_n = 1; adsc_n = 0; ce1_n = 0; addr = 8'h20; din = 36'h5_5555_5555;
    gw_n = 1; bw_en_n = 0; bwe_n = 4'b1010;
    step();
    idle();
    exp = mdl[8'h20];
    for (int l = 0; l < 4; l++)
      if (!bwe_n[l] || l == 0 || l == 2) exp[l*9 +: 9] = (l == 0 || l == 2) ? 9'h155 : exp[l*9 +: 9];
    mdl[8'h20] = exp;
    // R3 controller read: lane bits low but gate high means no write
    adsp_n = 1; adsc_n = 0; ce1_n = 0; addr = 8'h20; bw_en_n = 1; bwe_n = 4'b0000;
    din = 36'hF_FFFF_FFFF;
    step();
    idle();
    step();
    check("R3 adsc read valid", {35'd0, dvalid}, 36'd1);
    check("R4 lane mask", dout, exp);
    step();
    rd_check("R3 no write on gated lanes", 8'h20);
  endtask

  task automatic t_burst();
    logic [7:0] lin [4];
    logic [7:0] ilv [4];
    for (int i = 0; i < 4; i++) wr_word(8'h30 + 8'(i), 36'h3_0000_0000 + 36'(i * 17 + 5));
    for (int i = 0; i < 4; i++) begin
      lin[i] = {6'b001100, 2'(1 + i)};
      ilv[i] = {6'b001100, 2'(1) ^ 2'(i)};
    end
    adsp_n = 0; ce1_n = 0; adsc_n = 1; addr = 8'h31;
    step();
    adsp_n = 1; adsc_n = 1; adv_n = 0;
    for (int i = 0; i < 4; i++) begin
      if (i == 3) idle();
      step();
      check("R6 linear beat", dout, mdl[lin[i]]);
      check("R6 interleaved beat", dout_il, mdl[ilv[i]]);
      check("R6 beat valid", {35'd0, dvalid}, 36'd1);
      if (i == 2) idle();
    end
    step();
    check("R11 extra drive oe", {35'd0, doe}, 36'd1);
    check("R11 extra drive valid", {35'd0, dvalid}, 36'd0);
    check("R11 extra drive data", dout, mdl[lin[3]]);
    step();
    check("R11 drive off", {35'd0, doe}, 36'd0);
  endtask

  task automatic t_hold_oe();
    adsp_n = 0; ce1_n = 0; adsc_n = 1; addr = 8'h31;
    step();
    adsp_n = 1; adsc_n = 1; adv_n = 1;
    step();
    check("R7 hold beat0", dout, mdl[8'h31]);
    step();
    check("R7 hold beat1", dout, mdl[8'h31]);
    oe_n = 1;
    #1;
    check("R12 oe off", {35'd0, doe}, 36'd0);
    check("R12 data zero", dout, 36'd0);
    oe_n = 0;
    #1;
    check("R12 data back", dout, mdl[8'h31]);
    idle();
    repeat (3) step();
  endtask

  task automatic t_cont_write();
    adsp_n = 1; adsc_n = 0; ce1_n = 0; addr = 8'h40; din = 36'h4_0404_0404; gw_n = 0;
    step();
    adsc_n = 1; adv_n = 0; din = 36'h4_1414_1414;
    step();
    mdl[8'h40] = 36'h4_0404_0404;
    mdl[8'h41] = 36'h4_1414_1414;
    idle();
    step();
    rd_check("R8 continuation write", 8'h41);
    rd_check("R8 first write kept", 8'h40);
  endtask

  task automatic t_adsp_ignored();
    adsp_n = 0; ce1_n = 0; adsc_n = 1; addr = 8'h30;
    step();
    ce1_n = 1; addr = 8'h10; adv_n = 1;
    step();
    step();
    check("R9 ignored strobe valid", {35'd0, dvalid}, 36'd1);
    check("R9 burst kept", dout, mdl[8'h30]);
    idle();
    repeat (3) step();
  endtask

  task automatic t_adsp_write();
    adsp_n = 0; ce1_n = 0; adsc_n = 1; addr = 8'h10; gw_n = 0; din = 36'hD_EADB_EEF0;
    step();
    idle();
    step();
    check("R14 reads old data", dout, mdl[8'h10]);
    step();
    rd_check("R14 memory unchanged", 8'h10);
  endtask

  task automatic t_deselect();
    adsp_n = 1; adsc_n = 0; ce1_n = 0; ce2 = 0; addr = 8'h10; gw_n = 0; din = 36'h0_BAD0_BAD0;
    step();
    idle();
    step();
    check("R10 no data ce2", {35'd0, dvalid}, 36'd0);
    adsp_n = 0; adsc_n = 1; ce1_n = 0; ce3_n = 1; addr = 8'h10;
    step();
    idle();
    step();
    check("R10 no data ce3", {35'd0, dvalid}, 36'd0);
    check("R10 no drive", {35'd0, doe}, 36'd0);
    rd_check("R10 no write", 8'h10);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_read_after_write();
    t_bytes();
    t_burst();
    t_hold_oe();
    t_cont_write();
    t_adsp_ignored();
    t_adsp_write();
    t_deselect();
    summary();
    $finish;
  end
endmodule